// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel. It watches the count of one of two 16-bit timers and drives a single output pin. A 3-bit mode field in a control word sets the pin's behaviour. The modes are off, drive-high on match, drive-low on match, toggle on match, a single pulse, a continuous pulse train, and pulse-width modulation (PWM), with or without fault shutdown. Software programs a control word and two compare values through a simple register port. The timers only feed counts and period strobes into the block.

In the pulse modes, the pin rises when the count equals the primary value and falls when it equals the secondary value. In PWM, the pin rises on every period strobe of the selected timer and falls when the count reaches the active duty value. The duty value is refreshed from the secondary register only at a period strobe. An active-low fault input can shut the PWM output down, and a status flag records the fault until hardware clears it. An idle-halt option freezes the channel while the CPU idle input is high. A one-clock flag pulse marks each compare or period event.

Top module: `outCompareUnit`

## Requirements
- R1: After reset the mode, timer select and idle-halt fields and both compare values are 0, and the pin and event flag are low.
- R2: Mode 000 keeps the pin low and never raises the event flag.
- R3: Mode 001 starts the pin low and sets it high on a primary match. Mode 010 starts the pin high and clears it on a primary match. Each match raises the flag for one clock.
- R4: Mode 011 inverts the pin on each primary match and flags each one.
- R5: Mode 100 starts low, rises on the primary match and falls on the secondary match, then stays low. The mode field still reads 100 afterwards.
- R6: Mode 101 starts low and repeats the rise on the primary match and the fall on the secondary match for as long as it runs.
- R7: In modes 110 and 111 the pin rises and the flag pulses on each period strobe. The pin falls when the count equals the active duty value. The duty value is copied from the secondary register only at a period strobe or when the mode changes, so a mid-period write does not take effect until the next period.
- R8: Mode 110 ignores the fault input.
- R9: In mode 111 a low fault input drives the pin low at the next clock and sets the fault status. The status clears and the pin rises again at the first period strobe seen with the fault input high.
- R10: Writes to the fault status bit have no effect. Outside mode 111 the bit reads 0, and leaving mode 111 clears it.
- R11: The timer select bit chooses timer B when set and timer A when clear. Matches and period strobes come only from the chosen timer.
- R12: With idle-halt set and CPU idle high, the channel holds its pin and raises no flag. Fault shutdown in mode 111 still acts.
- R13: Register layout. Address 0 is the control word: bits 2:0 mode, bit 3 timer select, bit 4 fault status (read only), bit 5 idle-halt, all other bits read 0. Address 1 is the primary value and address 2 the secondary value. Address 3 reads 0.
- R14: A control write that changes the mode sets the pin to the new mode's starting level at the next clock. The starting level is high for mode 010 and low for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| timerA | input | 16 | Count of timer A |
| timerAPeriod | input | 1 | Period strobe of timer A |
| timerB | input | 16 | Count of timer B |
| timerBPeriod | input | 1 | Period strobe of timer B |
| faultN | input | 1 | Active-low fault input |
| cpuIdle | input | 1 | CPU idle indication |
| ocOut | output | 1 | Compare output pin |
| irqFlag | output | 1 | One-clock event flag |

## Verification
The assertions check these rules on every cycle:
- The pin stays low in mode 000.
- The fault status is never set outside mode 111, and it rises only after a low fault input in that mode.
- A low fault input pulls the pin down one clock later.
- A halted channel holds its pin.
- A finished single pulse stays low.

Other behaviours depend on a sequence of events, so only the bench scenarios can show them:
- the duty value not taking effect until the period after it is written;
- the single pulse happening exactly once;
- the pulse train repeating;
- the timer select choosing the right source;
- the fault status clearing at the right period strobe.

// File: rtl/ocPkg.sv
package ocPkg;

  typedef enum logic [2:0] {
    OC_OFF      = 3'b000,
    OC_RISE     = 3'b001,
    OC_FALL     = 3'b010,
    OC_TOGGLE   = 3'b011,
    OC_ONESHOT  = 3'b100,
    OC_TRAIN    = 3'b101,
    OC_PWM      = 3'b110,
    OC_PWM_FLT  = 3'b111
  } ocMode_e;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic reinit;
    logic initHigh;
    logic setPin;
    logic clrPin;
    logic togPin;
    logic loadDuty;
    logic irq;
    logic faultSet;
    logic faultClr;
  } ocStrobes_t;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEC  = 2'd2;

  localparam int MODE_W   = 3;
  localparam int SEL_BIT  = 3;
  localparam int FLT_BIT  = 4;
  localparam int IDLE_BIT = 5;

endpackage

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CNT_W-1:0]    regWrData,
  input  logic [CNT_W-1:0]    timerA,
  input  logic                timerAPeriod,
  input  logic [CNT_W-1:0]    timerB,
  input  logic                timerBPeriod,
  input  logic                faultN,
  input  logic                cpuIdle,
  input  logic                pinQ,
  input  logic                faultSt,
  input  logic [CNT_W-1:0]    dutyActive,
  output ocStrobes_t          strb,
  output ocMode_e             modeQ,
  output logic                tSelQ,
  output logic                idleStopQ,
  output logic [CNT_W-1:0]    priCmp,
  output logic [CNT_W-1:0]    secCmp
);

  logic             ctrlWr;
  ocMode_e          newMode;
  logic [CNT_W-1:0] selCnt;
  logic             selPer;
  logic             run;
  logic             priHit;
  logic             secHit;
  logic             dutyHit;
  logic             pwm;
  logic             doneQ;
  logic             doneSet;

  assign ctrlWr  = regWrEn && (regAddr == ADDR_CTRL);
  assign newMode = ocMode_e'(regWrData[MODE_W-1:0]);
  assign selCnt  = tSelQ ? timerB : timerA;
  assign selPer  = tSelQ ? timerBPeriod : timerAPeriod;
  assign run     = !(idleStopQ && cpuIdle);
  assign priHit  = (selCnt == priCmp);
  assign secHit  = (selCnt == secCmp);
  assign dutyHit = (selCnt == dutyActive);
  assign pwm     = (modeQ == OC_PWM) || (modeQ == OC_PWM_FLT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= OC_OFF;
      tSelQ     <= 1'b0;
      idleStopQ <= 1'b0;
      priCmp    <= '0;
      secCmp    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL: begin
          modeQ     <= newMode;
          tSelQ     <= regWrData[SEL_BIT];
          idleStopQ <= regWrData[IDLE_BIT];
        end
        ADDR_PRI: priCmp <= regWrData;
        ADDR_SEC: secCmp <= regWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            doneQ <= 1'b0;
    else if (strb.reinit) doneQ <= 1'b0;
    else if (doneSet)     doneQ <= 1'b1;
  end

  always_comb begin
    strb    = '0;
    doneSet = 1'b0;
    if (ctrlWr && (newMode != modeQ)) begin
      strb.reinit   = 1'b1;
      strb.initHigh = (newMode == OC_FALL);
    end else begin
      if (pwm && run && selPer) begin
        strb.loadDuty = 1'b1;
        strb.irq      = 1'b1;
      end
      if ((modeQ == OC_PWM_FLT) && !faultN) begin
        strb.clrPin   = 1'b1;
        strb.faultSet = 1'b1;
      end else if ((modeQ == OC_PWM_FLT) && faultSt) begin
        if (run && selPer) begin
          strb.faultClr = 1'b1;
          strb.setPin   = 1'b1;
        end
      end else if (run) begin
        case (modeQ)
          OC_RISE:   if (priHit) begin strb.setPin = 1'b1; strb.irq = 1'b1; end
          OC_FALL:   if (priHit) begin strb.clrPin = 1'b1; strb.irq = 1'b1; end
          OC_TOGGLE: if (priHit) begin strb.togPin = 1'b1; strb.irq = 1'b1; end
          OC_ONESHOT: begin
            if (!pinQ && !doneQ && priHit) begin
              strb.setPin = 1'b1;
              strb.irq    = 1'b1;
            end else if (pinQ && secHit) begin
              strb.clrPin = 1'b1;
              strb.irq    = 1'b1;
              doneSet     = 1'b1;
            end
          end
          OC_TRAIN: begin
            if (!pinQ && priHit) begin
              strb.setPin = 1'b1;
              strb.irq    = 1'b1;
            end else if (pinQ && secHit) begin
              strb.clrPin = 1'b1;
              strb.irq    = 1'b1;
            end
          end
          OC_PWM, OC_PWM_FLT: begin
            if (selPer)       strb.setPin = 1'b1;
            else if (dutyHit) strb.clrPin = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_off_pin_low: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == OC_OFF) |-> !pinQ);

  a_r10_fault_only_pwm_flt: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != OC_PWM_FLT) |-> !faultSt);

  a_r10_fault_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultSt) |-> ($past(!faultN) && (modeQ == OC_PWM_FLT)));

  a_r9_fault_forces_low: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == OC_PWM_FLT) && !faultN && !ctrlWr) |=> !pinQ);

  a_r12_idle_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (idleStopQ && cpuIdle && !ctrlWr && (modeQ != OC_PWM_FLT)) |=> $stable(pinQ));

  a_r5_oneshot_stays_low: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == OC_ONESHOT) && doneQ && !ctrlWr) |=> !pinQ);

endmodule

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ocStrobes_t       strb,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             pinQ,
  output logic             irqQ,
  output logic             faultSt,
  output logic [CNT_W-1:0] dutyActive
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ       <= 1'b0;
      irqQ       <= 1'b0;
      faultSt    <= 1'b0;
      dutyActive <= '0;
    end else begin
      irqQ <= strb.irq;
      if (strb.reinit) begin
        pinQ       <= strb.initHigh;
        faultSt    <= 1'b0;
        dutyActive <= dutyIn;
      end else begin
        if (strb.clrPin)      pinQ <= 1'b0;
        else if (strb.setPin) pinQ <= 1'b1;
        else if (strb.togPin) pinQ <= ~pinQ;
        if (strb.faultSet)      faultSt <= 1'b1;
        else if (strb.faultClr) faultSt <= 1'b0;
        if (strb.loadDuty) dutyActive <= dutyIn;
      end
    end
  end

  a_r9_fault_status_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    (strb.faultSet && !strb.reinit) |=> (faultSt && !pinQ));

  a_r1_flag_single_source: assert property (@(posedge clk) disable iff (!rstN)
    strb.reinit |=> !irqQ);

endmodule

// File: rtl/outCompareUnit.sv
module outCompareUnit
  import ocPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic [15:0] timerA,
  input  logic        timerAPeriod,
  input  logic [15:0] timerB,
  input  logic        timerBPeriod,
  input  logic        faultN,
  input  logic        cpuIdle,
  output logic        ocOut,
  output logic        irqFlag
);

  localparam int CNT_W = 16;

  ocStrobes_t       strb;
  ocMode_e          modeQ;
  logic             tSelQ;
  logic             idleStopQ;
  logic [CNT_W-1:0] priCmp;
  logic [CNT_W-1:0] secCmp;
  logic             pinQ;
  logic             faultSt;
  logic [CNT_W-1:0] dutyActive;

  ocCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .timerA       (timerA),
    .timerAPeriod (timerAPeriod),
    .timerB       (timerB),
    .timerBPeriod (timerBPeriod),
    .faultN       (faultN),
    .cpuIdle      (cpuIdle),
    .pinQ         (pinQ),
    .faultSt      (faultSt),
    .dutyActive   (dutyActive),
    .strb         (strb),
    .modeQ        (modeQ),
    .tSelQ        (tSelQ),
    .idleStopQ    (idleStopQ),
    .priCmp       (priCmp),
    .secCmp       (secCmp)
  );

  ocDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dutyIn     (secCmp),
    .pinQ       (pinQ),
    .irqQ       (irqFlag),
    .faultSt    (faultSt),
    .dutyActive (dutyActive)
  );

  assign ocOut = pinQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[MODE_W-1:0] = modeQ;
        regRdData[SEL_BIT]    = tSelQ;
        regRdData[FLT_BIT]    = faultSt;
        regRdData[IDLE_BIT]   = idleStopQ;
      end
      ADDR_PRI: regRdData = priCmp;
      ADDR_SEC: regRdData = secCmp;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: tb/outCompareUnit_bench.sv
module outCompareUnit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int A_PER = 20;
  localparam int B_PER = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [15:0] tA = '0;
  logic [15:0] tB = '0;
  logic        tAPer = 1'b0;
  logic        tBPer = 1'b0;
  logic        faultN = 1'b1;
  logic        cpuIdle = 1'b0;
  logic        ocOut;
  logic        irqFlag;

  int unsigned checks = 0;
  int unsigned fails = 0;
  string       curReq = "";

  logic [2:0]  mMode = 3'd0;
  logic        mSel = 1'b0, mIdleStop = 1'b0, mPin = 1'b0, mIrq = 1'b0;
  logic        mFlt = 1'b0, mDone = 1'b0;
  logic [15:0] mPri = '0, mSec = '0, mDuty = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outCompareUnit u_outCompareUnit (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regAddr(regAddr),
    .regWrData(wrData), .regRdData(rdData),
    .timerA(tA), .timerAPeriod(tAPer), .timerB(tB), .timerBPeriod(tBPer),
    .faultN(faultN), .cpuIdle(cpuIdle), .ocOut(ocOut), .irqFlag(irqFlag)
  );

  function automatic string reqForMode(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference behaviour, evaluated with the inputs present at a rising edge.
  task automatic modelUpdate();
    logic [15:0] cnt;
    logic        per, run, pin, irq, flt, done;
    logic [15:0] duty;
    cnt  = mSel ? tB : tA;
    per  = mSel ? tBPer : tAPer;
    run  = !(mIdleStop && cpuIdle);
    pin  = mPin; irq = 1'b0; flt = mFlt; done = mDone; duty = mDuty;
    if (wrEn && regAddr == 2'd0 && wrData[2:0] != mMode) begin
      pin  = (wrData[2:0] == 3'd2);
      flt  = 1'b0;
      done = 1'b0;
      duty = mSec;
    end else begin
      if (mMode >= 3'd6 && run && per) begin irq = 1'b1; duty = mSec; end
      if (mMode == 3'd7 && !faultN) begin
        pin = 1'b0; flt = 1'b1;
      end else if (mMode == 3'd7 && mFlt) begin
        if (run && per) begin flt = 1'b0; pin = 1'b1; end
      end else if (run) begin
        case (mMode)
          3'd1: if (cnt == mPri) begin pin = 1'b1; irq = 1'b1; end
          3'd2: if (cnt == mPri) begin pin = 1'b0; irq = 1'b1; end
          3'd3: if (cnt == mPri) begin pin = !mPin; irq = 1'b1; end
          3'd4: begin
            if (!mPin && !mDone && cnt == mPri) begin pin = 1'b1; irq = 1'b1; end
            else if (mPin && cnt == mSec) begin pin = 1'b0; irq = 1'b1; done = 1'b1; end
          end
          3'd5: begin
            if (!mPin && cnt == mPri) begin pin = 1'b1; irq = 1'b1; end
            else if (mPin && cnt == mSec) begin pin = 1'b0; irq = 1'b1; end
          end
          3'd6, 3'd7: begin
            if (per) pin = 1'b1;
            else if (cnt == mDuty) pin = 1'b0;
          end
          default: ;
        endcase
      end
    end
    if (wrEn) begin
      case (regAddr)
        2'd0: begin mMode = wrData[2:0]; mSel = wrData[3]; mIdleStop = wrData[5]; end
        2'd1: mPri = wrData;
        2'd2: mSec = wrData;
        default: ;
      endcase
    end
    mPin = pin; mIrq = irq; mFlt = flt; mDone = done; mDuty = duty;
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d);
    string req;
    wrEn = w; regAddr = a; wrData = d;
    tAPer = (tA == A_PER - 1);
    tBPer = (tB == B_PER - 1);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    wrEn = 1'b0;
    req = (curReq == "") ? reqForMode(mMode) : curReq;
    chk(req, {15'd0, ocOut}, {15'd0, mPin});
    chk(req, {15'd0, irqFlag}, {15'd0, mIrq});
    tA = (tA == A_PER - 1) ? 16'd0 : tA + 16'd1;
    tB = (tB == B_PER - 1) ? 16'd0 : tB + 16'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'd0);
  endtask

  task automatic untilA(input logic [15:0] v);
    while (tA != v) step(1'b0, 2'd0, 16'd0);
    step(1'b0, 2'd0, 16'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1'b1, a, d);
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    regAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic countRises(input int n, output int rises);
    logic prev;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      prev = ocOut;
      step(1'b0, 2'd0, 16'd0);
      if (!prev && ocOut) rises++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int rises;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    curReq = "R1";
    chk("R1", {15'd0, ocOut}, 16'd0);
    chk("R1", {15'd0, irqFlag}, 16'd0);
    rd("R1", 2'd0, 16'h0000);
    rd("R1", 2'd1, 16'h0000);
    rd("R1", 2'd2, 16'h0000);

    // R13 / R10: layout, unimplemented bits and read-only fault status
    curReq = "R13";
    wr(2'd0, 16'hFFFF);
    rd("R13", 2'd0, 16'h002F);
    wr(2'd1, 16'h1234);
    rd("R13", 2'd1, 16'h1234);
    rd("R13", 2'd3, 16'h0000);
    curReq = "R2";
    wr(2'd0, 16'h0000);
    idle(30);
    chk("R2", {15'd0, ocOut}, 16'd0);

    // R14 / R3: mode 010 starts high, falls on primary match
    curReq = "R3";
    wr(2'd1, 16'd7);
    wr(2'd0, 16'h0002);
    chk("R14", {15'd0, ocOut}, 16'd1);
    idle(25);
    chk("R3", {15'd0, ocOut}, 16'd0);

    // R11: timer B never reaches 15, timer A does
    curReq = "R11";
    wr(2'd1, 16'd15);
    wr(2'd0, 16'h0009);
    idle(40);
    chk("R11", {15'd0, ocOut}, 16'd0);
    wr(2'd0, 16'h0001);
    idle(25);
    chk("R11", {15'd0, ocOut}, 16'd1);

    // R12: idle-halt freezes toggle mode
    curReq = "R12";
    wr(2'd0, 16'h0023);
    chk("R14", {15'd0, ocOut}, 16'd0);
    cpuIdle = 1'b1;
    idle(40);
    chk("R12", {15'd0, ocOut}, 16'd0);
    cpuIdle = 1'b0;
    idle(20);
    chk("R12", {15'd0, ocOut}, 16'd1);

    // R5: single pulse
    curReq = "R5";
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd8);
    wr(2'd0, 16'h0004);
    countRises(60, rises);
    chk("R5", 16'(rises), 16'd1);
    chk("R5", {15'd0, ocOut}, 16'd0);
    rd("R5", 2'd0, 16'h0004);

    // R6: continuous pulses, three periods of timer A
    curReq = "R6";
    wr(2'd0, 16'h0005);
    countRises(60, rises);
    chk("R6", 16'(rises), 16'd3);

    // R7: PWM duty takes effect only at the next period
    curReq = "R7";
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0006);
    idle(40);
    while (tA != 16'd2) step(1'b0, 2'd0, 16'd0);
    wr(2'd2, 16'd15);
    untilA(16'd10);
    chk("R7", {15'd0, ocOut}, 16'd0);
    untilA(16'd10);
    chk("R7", {15'd0, ocOut}, 16'd1);

    // R8: mode 110 ignores the fault input
    curReq = "R8";
    faultN = 1'b0;
    idle(30);
    untilA(16'd3);
    chk("R8", {15'd0, ocOut}, 16'd1);
    rd("R8", 2'd0, 16'h0006);
    faultN = 1'b1;

    // R9: fault shutdown and hardware clear
    curReq = "R9";
    wr(2'd0, 16'h0007);
    untilA(16'd19);
    untilA(16'd2);
    chk("R9", {15'd0, ocOut}, 16'd1);
    faultN = 1'b0;
    step(1'b0, 2'd0, 16'd0);
    chk("R9", {15'd0, ocOut}, 16'd0);
    rd("R9", 2'd0, 16'h0017);
    faultN = 1'b1;
    untilA(16'd10);
    chk("R9", {15'd0, ocOut}, 16'd0);
    rd("R9", 2'd0, 16'h0017);
    untilA(16'd19);
    chk("R9", {15'd0, ocOut}, 16'd1);
    rd("R9", 2'd0, 16'h0007);

    // R10: status write ignored; leaving mode 111 clears it
    curReq = "R10";
    wr(2'd0, 16'h0017);
    rd("R10", 2'd0, 16'h0007);
    faultN = 1'b0;
    step(1'b0, 2'd0, 16'd0);
    rd("R10", 2'd0, 16'h0017);
    wr(2'd0, 16'h0006);
    rd("R10", 2'd0, 16'h0006);
    faultN = 1'b1;

    // Random phase: all modes, both timers, idle and fault noise
    curReq = "";
    for (int r = 0; r < 40; r++) begin
      wr(2'd1, 16'($urandom % 20));
      wr(2'd2, 16'($urandom % 20));
      wr(2'd0, 16'($urandom & 32'h3F));
      for (int c = 0; c < 60; c++) begin
        cpuIdle = (($urandom % 8) == 0);
        faultN  = (($urandom % 10) != 0);
        step(1'b0, 2'd0, 16'd0);
      end
      cpuIdle = 1'b0;
      faultN  = 1'b1;
    end

    summary();
    $finish;
  end

endmodule